// File: doc/BRIEF.md
# Configuration Access Forwarding Translator

This block sits behind the upstream port of a bus-to-bus bridge and decides what the bridge does with each configuration access. It looks at the bus command, the address word of the access and the device-select input. From those it picks one action. It can claim a Type 0 access for the bridge's own registers. It can turn a Type 1 access aimed at the directly attached downstream bus into a Type 0 access that carries a one-hot select line. It can forward a Type 1 access for a deeper bus unchanged. It can turn a qualifying configuration write into a special cycle. Otherwise it drops the access.

The downstream and subordinate bus numbers arrive on input ports and set the routing window. For every access it takes, the block also returns the address and command to present on the far side, together with a flag that limits the transfer to one DWORD. That flag tells the bus engine to disconnect after the first data phase. All outputs are registered and appear one clock after the request.

Type 1 address fields: bits [1:0] = 01b, register number [7:2], function number [10:8], device number [15:11], bus number [23:16]. Configuration read is command 1010b, configuration write is 1011b, and special cycle is 0001b.

Top module: `cfgfwd_top`

## Requirements
- R1: A configuration read or write with address bits [1:0] = 00b and the select input high is claimed (action code 1). The address and command are returned unchanged.
- R2: The single-DWORD flag is high for every action other than ignore, and low for ignore.
- R3: A Type 1 access whose bus number equals the downstream bus number, and which is not a special-cycle request, is converted (action code 2). The output address keeps the function and register fields [10:2] and has bits [1:0] = 00b. The command is unchanged.
- R4: On conversion, device number d from 0 to 15 sets address bit 16+d alone among bits [31:11]. Device numbers 16 to 31 set none of bits [31:11].
- R5: A Type 1 access whose bus number is greater than the downstream bus number and no greater than the subordinate bus number passes through (action code 3). Address and command are unchanged, so bits [1:0] stay 01b.
- R6: A configuration write on the downstream bus with device 31, function 7 and register 0 becomes a special cycle (action code 4). The command is 0001b and the address is unchanged. A read with the same fields is converted as in R3.
- R7: All other accesses are ignored (action code 0), with the output address and command zero. This covers a non-configuration command, address bits [1:0] = 1xb, a Type 0 access with the select input low, and a bus number below the downstream bus or above the subordinate bus.
- R8: Outputs are registered. Each request appears on the outputs one clock after it is presented, and the valid output follows the request valid input. Synchronous reset clears every output to zero, and a cycle without a request gives valid low with every output field zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A configuration access is presented this cycle |
| req_cmd | input | 4 | Bus command of the access |
| req_addr | input | 32 | Address word of the access |
| req_idsel | input | 1 | Device-select input for the bridge itself |
| dn_bus | input | 8 | Bus number of the directly attached downstream bus |
| sub_bus | input | 8 | Highest bus number reachable below the bridge |
| fwd_valid | output | 1 | Decision valid |
| fwd_act | output | 3 | Action: 0 ignore, 1 claim, 2 convert, 3 pass, 4 special |
| fwd_addr | output | 32 | Address to drive on the far side |
| fwd_cmd | output | 4 | Command to drive on the far side |
| fwd_single | output | 1 | Limit the transfer to one DWORD |

## Verification
The assertions check several properties on every decision. A converted address has at most one select line set and low bits 00b. Pass-through addresses equal the incoming address. Special cycles come only from writes and carry command 0001b. Claims occur only with the select input high. The single-DWORD flag accompanies every non-ignore action, and a cycle without a request gives ignore. Only the bench scenarios can show the other behaviours: which select bit each device number lights, where the boundaries of the bus-number window fall, that reads are kept apart from special-cycle writes, and that the preserved register and function fields are correct.

// File: rtl/cfgfwd_pkg.sv
package cfgfwd_pkg;

  typedef enum logic [2:0] {
    ACT_IGNORE  = 3'd0,
    ACT_CLAIM   = 3'd1,
    ACT_CONVERT = 3'd2,
    ACT_PASS    = 3'd3,
    ACT_SPECIAL = 3'd4
  } fwd_act_e;

  localparam logic [3:0] CMD_SPECIAL = 4'b0001;
  localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR  = 4'b1011;

  localparam int REG_LSB = 2;
  localparam int REG_W   = 6;
  localparam int FN_LSB  = 8;
  localparam int FN_W    = 3;
  localparam int DEV_LSB = 11;
  localparam int DEV_W   = 5;
  localparam int BUS_LSB = 16;

endpackage

// File: rtl/cfgfwd_classify.sv
module cfgfwd_classify
  import cfgfwd_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int HDR_W = BUS_LSB + BUS_W
) (
  input  logic [3:0]       cmd_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic             idsel_i,
  input  logic [BUS_W-1:0] dn_bus_i,
  input  logic [BUS_W-1:0] sub_bus_i,
  output fwd_act_e         act_o
);

  logic             is_cfg;
  logic             is_wr;
  logic [BUS_W-1:0] bus;
  logic [DEV_W-1:0] dev;
  logic [FN_W-1:0]  fn;
  logic [REG_W-1:0] rnum;
  logic             spc_fields;

  assign is_cfg     = (cmd_i == CMD_CFG_RD) || (cmd_i == CMD_CFG_WR);
  assign is_wr      = (cmd_i == CMD_CFG_WR);
  assign bus        = hdr_i[BUS_LSB +: BUS_W];
  assign dev        = hdr_i[DEV_LSB +: DEV_W];
  assign fn         = hdr_i[FN_LSB +: FN_W];
  assign rnum       = hdr_i[REG_LSB +: REG_W];
  assign spc_fields = (&dev) && (&fn) && (rnum == '0);

  always_comb begin
    act_o = ACT_IGNORE;
    if (is_cfg) begin
      unique case (hdr_i[1:0])
        2'b00: if (idsel_i) act_o = ACT_CLAIM;
        2'b01: begin
          if (bus == dn_bus_i)
            act_o = (is_wr && spc_fields) ? ACT_SPECIAL : ACT_CONVERT;
          else if ((bus > dn_bus_i) && (bus <= sub_bus_i))
            act_o = ACT_PASS;
        end
        default: act_o = ACT_IGNORE;
      endcase
    end
  end

endmodule

// File: rtl/cfgfwd_idsel_dec.sv
module cfgfwd_idsel_dec
  import cfgfwd_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic [DEV_W-1:0] dev_i,
  output logic [LINES-1:0] sel_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign sel_o[g] = (dev_i == DEV_W'(g));
  end

endmodule

// File: rtl/cfgfwd_addr_build.sv
module cfgfwd_addr_build
  import cfgfwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int LINES = ADDR_W - BUS_LSB
) (
  input  fwd_act_e          act_i,
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LINES-1:0]  sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [3:0]        cmd_o
);

  always_comb begin
    addr_o = '0;
    cmd_o  = '0;
    unique case (act_i)
      ACT_CLAIM, ACT_PASS: begin
        addr_o = addr_i;
        cmd_o  = cmd_i;
      end
      ACT_CONVERT: begin
        addr_o[BUS_LSB +: LINES]  = sel_i;
        addr_o[DEV_LSB-1:REG_LSB] = addr_i[DEV_LSB-1:REG_LSB];
        cmd_o                     = cmd_i;
      end
      ACT_SPECIAL: begin
        addr_o = addr_i;
        cmd_o  = CMD_SPECIAL;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cfgfwd_top.sv
module cfgfwd_top
  import cfgfwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 8,
  localparam int LINES = ADDR_W - BUS_LSB,
  localparam int HDR_W = BUS_LSB + BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_idsel,
  input  logic [BUS_W-1:0]  dn_bus,
  input  logic [BUS_W-1:0]  sub_bus,
  output logic              fwd_valid,
  output logic [2:0]        fwd_act,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [3:0]        fwd_cmd,
  output logic              fwd_single
);

  fwd_act_e          act_c;
  logic [LINES-1:0]  sel_c;
  logic [ADDR_W-1:0] addr_c;
  logic [3:0]        cmd_c;

  cfgfwd_classify #(.BUS_W(BUS_W)) u_cls (
    .cmd_i     (req_cmd),
    .hdr_i     (req_addr[HDR_W-1:0]),
    .idsel_i   (req_idsel),
    .dn_bus_i  (dn_bus),
    .sub_bus_i (sub_bus),
    .act_o     (act_c)
  );

  cfgfwd_idsel_dec #(.LINES(LINES)) u_dec (
    .dev_i (req_addr[DEV_LSB +: DEV_W]),
    .sel_o (sel_c)
  );

  cfgfwd_addr_build #(.ADDR_W(ADDR_W)) u_bld (
    .act_i  (act_c),
    .cmd_i  (req_cmd),
    .addr_i (req_addr),
    .sel_i  (sel_c),
    .addr_o (addr_c),
    .cmd_o  (cmd_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid  <= 1'b0;
      fwd_act    <= ACT_IGNORE;
      fwd_addr   <= '0;
      fwd_cmd    <= '0;
      fwd_single <= 1'b0;
    end else begin
      fwd_valid  <= req_valid;
      fwd_act    <= req_valid ? act_c : ACT_IGNORE;
      fwd_addr   <= req_valid ? addr_c : '0;
      fwd_cmd    <= req_valid ? cmd_c : '0;
      fwd_single <= req_valid && (act_c != ACT_IGNORE);
    end
  end

  AST_CONV_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (fwd_act == ACT_CONVERT) |-> $onehot0(fwd_addr[ADDR_W-1:BUS_LSB])); // R4
  AST_CONV_TYPE0: assert property (@(posedge clk) disable iff (rst)
    (fwd_act == ACT_CONVERT) |-> (fwd_addr[1:0] == 2'b00)); // R3
  AST_PASS_SAME: assert property (@(posedge clk) disable iff (rst)
    (fwd_act == ACT_PASS) |-> (fwd_addr == $past(req_addr) && fwd_cmd == $past(req_cmd))); // R5
  AST_SPECIAL_WR: assert property (@(posedge clk) disable iff (rst)
    (fwd_act == ACT_SPECIAL) |-> (fwd_cmd == CMD_SPECIAL && $past(req_cmd) == CMD_CFG_WR)); // R6
  AST_CLAIM_SEL: assert property (@(posedge clk) disable iff (rst)
    (fwd_act == ACT_CLAIM) |-> $past(req_idsel)); // R1
  AST_SINGLE_DW: assert property (@(posedge clk) disable iff (rst)
    (fwd_act != ACT_IGNORE) |-> fwd_single); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !fwd_valid |-> (fwd_act == ACT_IGNORE && fwd_addr == '0 && !fwd_single)); // R8

endmodule

// File: tb/cfgfwd_top_test.sv
module cfgfwd_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_cmd = '0;
  logic [31:0] req_addr = '0;
  logic        req_idsel = 1'b0;
  logic [7:0]  dn_bus = 8'h05;
  logic [7:0]  sub_bus = 8'h09;
  logic        fwd_valid;
  logic [2:0]  fwd_act;
  logic [31:0] fwd_addr;
  logic [3:0]  fwd_cmd;
  logic        fwd_single;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfgfwd_top uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_idsel(req_idsel), .dn_bus(dn_bus),
    .sub_bus(sub_bus), .fwd_valid(fwd_valid), .fwd_act(fwd_act),
    .fwd_addr(fwd_addr), .fwd_cmd(fwd_cmd), .fwd_single(fwd_single)
  );

  // {cmd, addr, idsel, exp_act, exp_addr, exp_cmd}; window dn=05 sub=09
  localparam int NV = 15;
  localparam logic [75:0] VEC [NV] = '{
    {4'hA, 32'h0000_0010, 1'b1, 3'd1, 32'h0000_0010, 4'hA}, // R1 claim
    {4'hA, 32'h0000_0010, 1'b0, 3'd0, 32'h0000_0000, 4'h0}, // R7 no select
    {4'hB, 32'h0000_0012, 1'b1, 3'd0, 32'h0000_0000, 4'h0}, // R7 low bits 10
    {4'hA, 32'h0005_1A11, 1'b0, 3'd2, 32'h0008_0210, 4'hA}, // R3 R4 dev3
    {4'hB, 32'h0005_78FD, 1'b0, 3'd2, 32'h8000_00FC, 4'hB}, // R4 dev15
    {4'hA, 32'h0005_0705, 1'b0, 3'd2, 32'h0001_0704, 4'hA}, // R4 dev0
    {4'hA, 32'h0005_A109, 1'b0, 3'd2, 32'h0000_0108, 4'hA}, // R4 dev20 none
    {4'hB, 32'h0005_FF01, 1'b0, 3'd4, 32'h0005_FF01, 4'h1}, // R6 special
    {4'hA, 32'h0005_FF01, 1'b0, 3'd2, 32'h0000_0700, 4'hA}, // R6 read converts
    {4'hA, 32'h0006_1A11, 1'b0, 3'd3, 32'h0006_1A11, 4'hA}, // R5 bus 6
    {4'hB, 32'h0009_0005, 1'b0, 3'd3, 32'h0009_0005, 4'hB}, // R5 bus = sub
    {4'hA, 32'h000A_0005, 1'b0, 3'd0, 32'h0000_0000, 4'h0}, // R7 above sub
    {4'hA, 32'h0004_0005, 1'b0, 3'd0, 32'h0000_0000, 4'h0}, // R7 below dn
    {4'h6, 32'h0005_0005, 1'b0, 3'd0, 32'h0000_0000, 4'h0}, // R7 mem read
    {4'hB, 32'h0006_FF01, 1'b0, 3'd3, 32'h0006_FF01, 4'hB}  // R5 deeper special
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] c, input logic [31:0] a, input logic s);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_idsel = s;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset valid", 64'(fwd_valid), 64'd0);
    chk("R8 reset addr", 64'(fwd_addr), 64'd0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][75:72], VEC[i][71:40], VEC[i][39]);
      chk("R8 valid", 64'(fwd_valid), 64'd1);
      chk("R1/R3/R5/R6/R7 act", 64'(fwd_act), 64'(VEC[i][38:36]));
      chk("R3/R4/R5/R6 addr", 64'(fwd_addr), 64'(VEC[i][35:4]));
      chk("R6/R7 cmd", 64'(fwd_cmd), 64'(VEC[i][3:0]));
      chk("R2 single", 64'(fwd_single), 64'(VEC[i][38:36] != 3'd0));
    end
    @(negedge clk);
    chk("R8 idle valid", 64'(fwd_valid), 64'd0);
    chk("R8 idle act", 64'(fwd_act), 64'd0);
    // narrow window: downstream equals subordinate
    dn_bus = 8'h20; sub_bus = 8'h20;
    send(4'hA, 32'h0020_2001, 1'b0);
    chk("R3 narrow convert act", 64'(fwd_act), 64'd2);
    chk("R4 narrow dev4", 64'(fwd_addr), 64'h0010_0000);
    send(4'hA, 32'h0021_2001, 1'b0);
    chk("R7 narrow above", 64'(fwd_act), 64'd0);
    chk("R2 narrow single", 64'(fwd_single), 64'd0);
    send(4'hB, 32'h0000_0003, 1'b1);
    chk("R7 low bits 11", 64'(fwd_act), 64'd0);
    // reset mid-stream clears outputs
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 4'hA; req_addr = 32'h10; req_idsel = 1'b1; rst = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; rst = 1'b0;
    chk("R8 reset wins", 64'(fwd_act), 64'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule